// File: doc/BRIEF.md
# Configurable Read-Only Flash Line Cache

This block sits between a processor's instruction/data access port and a slow flash array. It keeps copies of 128-bit flash lines. The processor raises a single-word read request and holds it. The block answers from its line store on a hit, or fetches the whole line from flash on a miss. The storage is organised as two banks of `SETS` lines. A run-time geometry field uses them as one direct-mapped bank, as a two-way set-associative cache, or as one direct-mapped cache of twice the depth.

Software programs the block through a small word-addressed register port. Through it, software selects the geometry, which traffic types are cached and the two-way victim policy. It can also enable or disable caching, start a full invalidate, clear the hit and miss counters and set two address windows that bypass the cache. Any access that is not cached still completes through flash with the same latency as a miss. It neither allocates a line nor touches the counters.

Top module: `flash_line_cache`

## Requirements
- R1: After reset the configuration word reads 0, the control word reads 2 (bit1 ready = 1, bit0 enabled = 0), and both counters read 0.
- R2: A cached miss issues one flash request at the 16-byte-aligned line address and returns the addressed 32-bit word. Later reads of any word in that line hit without a flash request.
- R3: Configuration word (index 0) bits [1:0] select the geometry: 0 is direct-mapped over 512 sets using bank 0 only; 1 is two-way over 512 sets; 2 is direct-mapped over 1024 lines, with address bit 13 choosing the bank.
- R4: Configuration bits [3:2] select the cached traffic: 0 caches nothing, 1 caches instruction reads only, 2 caches data reads only, 3 caches both. An uncached access reads flash, allocates nothing and leaves both counters unchanged.
- R5: In the two-way geometry, configuration bit 4 = 1 selects least-recently-used replacement, updated on hits and fills. Bit 4 = 0 selects least-recently-replaced, where only fills move the victim pointer.
- R6: Two bypass windows (start/end at register indices 4/5 and 6/7, enables at index 8 bits [1:0]) use inclusive byte-address bounds. An access inside an enabled window is uncached. A window whose end is below its start matches nothing.
- R7: Writing control bit2 starts an invalidate sweep that clears one set per cycle across both banks. Ready reads 0 for 512 cycles, no access completes meanwhile, and afterwards every line misses.
- R8: Writing control bit3 zeroes both counters (hits at index 2, misses at index 3). Each counter advances by at most one per access.
- R9: Any write to the configuration word clears the enable. Until control bit0 is written, no access is served as a hit. Control bit1 disables.
- R10: A hit completes one cycle after the request is sampled. A miss completes in the cycle the flash acknowledge arrives. The flash request stays high with a stable address until acknowledged. The acknowledge is a one-cycle pulse while the request is still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register word index |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data (combinational) |
| acc_req_i | input | 1 | Read request, held until acknowledged |
| acc_instr_i | input | 1 | 1 = instruction fetch, 0 = data load |
| acc_addr_i | input | ADDR_W | Byte address of the request |
| acc_ack_o | output | 1 | One-cycle completion pulse |
| acc_rdata_o | output | 32 | Addressed word, valid with acc_ack_o |
| fl_req_o | output | 1 | Flash line request |
| fl_addr_o | output | ADDR_W | Line-aligned flash address |
| fl_ack_i | input | 1 | Flash line valid pulse |
| fl_line_i | input | LINE_W | Flash line data, word 0 in the low bits |

## Verification
A corrupted valid bit, tag or victim pointer shows up at the flash port within one access. An extra or missing flash request appears on the next read of the affected set, and the hit or miss counter moves the wrong way. The flash model's contents can be changed while lines are resident, so a stale or wrongly selected line shows as a wrong returned word on the very next hit. A victim pointer that drifts from the chosen policy only becomes visible on the third distinct tag in a set. The replacement scenarios therefore read back the older line after forcing an eviction.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int NRGN = 2;

  localparam logic [1:0] GEO_DM512  = 2'd0;
  localparam logic [1:0] GEO_2W512  = 2'd1;
  localparam logic [1:0] GEO_DM1024 = 2'd2;

  localparam logic [3:0] REG_CFG   = 4'd0;
  localparam logic [3:0] REG_CTRL  = 4'd1;
  localparam logic [3:0] REG_HITS  = 4'd2;
  localparam logic [3:0] REG_MISS  = 4'd3;
  localparam logic [3:0] REG_R0LO  = 4'd4;
  localparam logic [3:0] REG_R0HI  = 4'd5;
  localparam logic [3:0] REG_R1LO  = 4'd6;
  localparam logic [3:0] REG_R1HI  = 4'd7;
  localparam logic [3:0] REG_RGNEN = 4'd8;

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_FILL} fsm_e;
endpackage

// File: rtl/fc_regs.sv
module fc_regs
  import fc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cfg_we_i,
  input  logic [3:0]                   cfg_addr_i,
  input  logic [31:0]                  cfg_wdata_i,
  output logic [31:0]                  cfg_rdata_o,
  output logic [1:0]                   geo_o,
  output logic [1:0]                   mode_o,
  output logic                         lru_o,
  output logic                         en_o,
  output logic                         inv_o,
  output logic [NRGN-1:0]              rgn_en_o,
  output logic [NRGN-1:0][ADDR_W-1:0]  rgn_lo_o,
  output logic [NRGN-1:0][ADDR_W-1:0]  rgn_hi_o,
  input  logic                         ready_i,
  input  logic                         hit_inc_i,
  input  logic                         miss_inc_i
);
  logic [4:0]       cfg_q;
  logic             en_q;
  logic [CNT_W-1:0] hit_q, miss_q;
  logic             wr_cfg, wr_ctrl, stat_clr;

  assign wr_cfg   = cfg_we_i && (cfg_addr_i == REG_CFG);
  assign wr_ctrl  = cfg_we_i && (cfg_addr_i == REG_CTRL);
  assign inv_o    = wr_ctrl && cfg_wdata_i[2];
  assign stat_clr = wr_ctrl && cfg_wdata_i[3];

  assign geo_o  = cfg_q[1:0];
  assign mode_o = cfg_q[3:2];
  assign lru_o  = cfg_q[4];
  assign en_o   = en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      en_q     <= 1'b0;
      rgn_en_o <= '0;
      rgn_lo_o <= '0;
      rgn_hi_o <= '0;
    end else if (cfg_we_i) begin
      case (cfg_addr_i)
        REG_CFG: begin
          cfg_q <= cfg_wdata_i[4:0];
          en_q  <= 1'b0;  // new setup always lands disabled
        end
        REG_CTRL: begin
          if (cfg_wdata_i[1])      en_q <= 1'b0;
          else if (cfg_wdata_i[0]) en_q <= 1'b1;
        end
        REG_R0LO:  rgn_lo_o[0] <= cfg_wdata_i[ADDR_W-1:0];
        REG_R0HI:  rgn_hi_o[0] <= cfg_wdata_i[ADDR_W-1:0];
        REG_R1LO:  rgn_lo_o[1] <= cfg_wdata_i[ADDR_W-1:0];
        REG_R1HI:  rgn_hi_o[1] <= cfg_wdata_i[ADDR_W-1:0];
        REG_RGNEN: rgn_en_o    <= cfg_wdata_i[NRGN-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= '0;
      miss_q <= '0;
    end else if (stat_clr) begin
      hit_q  <= '0;
      miss_q <= '0;
    end else begin
      hit_q  <= hit_q + CNT_W'(hit_inc_i);
      miss_q <= miss_q + CNT_W'(miss_inc_i);
    end
  end

  always_comb begin
    case (cfg_addr_i)
      REG_CFG:   cfg_rdata_o = 32'(cfg_q);
      REG_CTRL:  cfg_rdata_o = {30'b0, ready_i, en_q};
      REG_HITS:  cfg_rdata_o = 32'(hit_q);
      REG_MISS:  cfg_rdata_o = 32'(miss_q);
      REG_R0LO:  cfg_rdata_o = 32'(rgn_lo_o[0]);
      REG_R0HI:  cfg_rdata_o = 32'(rgn_hi_o[0]);
      REG_R1LO:  cfg_rdata_o = 32'(rgn_lo_o[1]);
      REG_R1HI:  cfg_rdata_o = 32'(rgn_hi_o[1]);
      REG_RGNEN: cfg_rdata_o = 32'(rgn_en_o);
      default:   cfg_rdata_o = '0;
    endcase
  end

  // R9
  cfg_disables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cfg |=> !en_q);
  // R8
  stat_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_clr |=> (hit_q == '0) && (miss_q == '0));
  // R8
  hit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_clr |=> (CNT_W'(hit_q - $past(hit_q)) <= CNT_W'(1)));
  // R8
  miss_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_clr |=> (CNT_W'(miss_q - $past(miss_q)) <= CNT_W'(1)));
endmodule

// File: rtl/fc_bypass.sv
module fc_bypass #(
  parameter int ADDR_W = 32,
  parameter int NRGN   = 2
) (
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [NRGN-1:0]              en_i,
  input  logic [NRGN-1:0][ADDR_W-1:0]  lo_i,
  input  logic [NRGN-1:0][ADDR_W-1:0]  hi_i,
  output logic                         hit_o
);
  logic [NRGN-1:0] in_rgn;

  for (genvar g = 0; g < NRGN; g++) begin : g_rgn
    // inclusive bounds; an inverted window cannot satisfy both
    assign in_rgn[g] = en_i[g] && (addr_i >= lo_i[g]) && (addr_i <= hi_i[g]);
  end

  assign hit_o = |in_rgn;
endmodule

// File: rtl/fc_way.sv
module fc_way #(
  parameter int SETS   = 512,
  parameter int TAG_W  = 19,
  parameter int LINE_W = 128,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [LINE_W-1:0] rd_line_o,
  input  logic              fill_we_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [LINE_W-1:0] fill_line_i,
  input  logic              clr_we_i,
  input  logic [IDX_W-1:0]  clr_idx_i
);
  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else begin
      if (fill_we_i) valid_q[rd_idx_i]  <= 1'b1;
      if (clr_we_i)  valid_q[clr_idx_i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_we_i) begin
      tag_q[rd_idx_i]  <= fill_tag_i;
      line_q[rd_idx_i] <= fill_line_i;
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_line_o  = line_q[rd_idx_i];

  // R2
  fill_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_we_i && !clr_we_i) |=> valid_q[$past(rd_idx_i)]);
endmodule

// File: rtl/flash_line_cache.sv
module flash_line_cache
  import fc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 128,
  parameter int SETS   = 512,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [3:0]        cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              acc_req_i,
  input  logic              acc_instr_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic              acc_ack_o,
  output logic [31:0]       acc_rdata_o,
  output logic              fl_req_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  input  logic              fl_ack_i,
  input  logic [LINE_W-1:0] fl_line_i
);
  localparam int NWAY   = 2;
  localparam int OFS_W  = $clog2(LINE_W / 8);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFS_W - IDX_W;
  localparam int WSEL_W = $clog2(LINE_W / 32);

  logic [1:0]                  geo, mode;
  logic                        lru, en, inv, ready, hit_inc, miss_inc;
  logic [NRGN-1:0]             rgn_en;
  logic [NRGN-1:0][ADDR_W-1:0] rgn_lo, rgn_hi;

  fc_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .geo_o(geo), .mode_o(mode), .lru_o(lru), .en_o(en), .inv_o(inv),
    .rgn_en_o(rgn_en), .rgn_lo_o(rgn_lo), .rgn_hi_o(rgn_hi),
    .ready_i(ready), .hit_inc_i(hit_inc), .miss_inc_i(miss_inc)
  );

  fsm_e              state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              instr_q;
  logic [IDX_W-1:0]  idx, sw_idx;
  logic [TAG_W-1:0]  tag;
  logic [WSEL_W-1:0] wsel;
  logic              bank, byp_hit, cach, vic, any_hit;
  logic              sweep_q, pend_q, sweep_go, accept, hit_ack, fill_done;
  logic [NWAY-1:0]   way_mask, way_hit, fill_we, rd_valid;
  logic [TAG_W-1:0]  rd_tag  [NWAY];
  logic [LINE_W-1:0] rd_line [NWAY];
  logic [LINE_W-1:0] hit_line, src_line;
  logic [SETS-1:0]   repl_q;  // per set: way to evict next

  assign idx  = addr_q[OFS_W +: IDX_W];
  assign tag  = addr_q[ADDR_W-1 -: TAG_W];
  assign bank = addr_q[OFS_W + IDX_W];
  assign wsel = addr_q[2 +: WSEL_W];

  fc_bypass #(.ADDR_W(ADDR_W), .NRGN(NRGN)) u_bypass (
    .addr_i(addr_q), .en_i(rgn_en), .lo_i(rgn_lo), .hi_i(rgn_hi), .hit_o(byp_hit)
  );

  always_comb begin
    case (geo)
      GEO_2W512:  way_mask = 2'b11;
      GEO_DM1024: way_mask = bank ? 2'b10 : 2'b01;
      default:    way_mask = 2'b01;
    endcase
    case (geo)
      GEO_2W512:  vic = repl_q[idx];
      GEO_DM1024: vic = bank;
      default:    vic = 1'b0;
    endcase
  end

  for (genvar w = 0; w < NWAY; w++) begin : g_way
    fc_way #(.SETS(SETS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_way (
      .clk_i, .rst_ni,
      .rd_idx_i(idx), .rd_valid_o(rd_valid[w]), .rd_tag_o(rd_tag[w]),
      .rd_line_o(rd_line[w]),
      .fill_we_i(fill_we[w]), .fill_tag_i(tag), .fill_line_i(fl_line_i),
      .clr_we_i(sweep_q), .clr_idx_i(sw_idx)
    );
    assign way_hit[w] = way_mask[w] && rd_valid[w] && (rd_tag[w] == tag);
    assign fill_we[w] = fill_done && cach && (vic == 1'(w));
  end

  assign any_hit   = |way_hit;
  assign cach      = en && (instr_q ? mode[0] : mode[1]) && !byp_hit;
  assign sweep_go  = inv || pend_q;
  assign ready     = !sweep_q && !pend_q;
  assign accept    = (state_q == ST_IDLE) && acc_req_i && !sweep_q && !sweep_go;
  assign hit_ack   = (state_q == ST_LOOK) && cach && any_hit;
  assign fill_done = (state_q == ST_FILL) && fl_ack_i;
  assign hit_inc   = hit_ack;
  assign miss_inc  = fill_done && cach;

  assign hit_line    = way_hit[1] ? rd_line[1] : rd_line[0];
  assign src_line    = (state_q == ST_FILL) ? fl_line_i : hit_line;
  assign acc_rdata_o = src_line[32*wsel +: 32];
  assign acc_ack_o   = hit_ack || fill_done;
  assign fl_req_o    = (state_q == ST_FILL);
  assign fl_addr_o   = {addr_q[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept) state_d = ST_LOOK;
      ST_LOOK: state_d = hit_ack ? ST_IDLE : ST_FILL;
      ST_FILL: if (fl_ack_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      instr_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= acc_addr_i;
        instr_q <= acc_instr_i;
      end
    end
  end

  // sweep starts only between accesses so no fill races it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sweep_q <= 1'b0;
      pend_q  <= 1'b0;
      sw_idx  <= '0;
    end else if (sweep_q) begin
      if (sw_idx == IDX_W'(SETS - 1)) sweep_q <= 1'b0;
      sw_idx <= sw_idx + 1'b1;
    end else if (sweep_go) begin
      if (state_q == ST_IDLE) begin
        sweep_q <= 1'b1;
        sw_idx  <= '0;
        pend_q  <= 1'b0;
      end else begin
        pend_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      repl_q <= '0;
    end else if (sweep_q) begin
      repl_q[sw_idx] <= 1'b0;
    end else if (geo == GEO_2W512) begin
      if (fill_done && cach)  repl_q[idx] <= ~vic;
      else if (hit_ack && lru) repl_q[idx] <= ~way_hit[1];
    end
  end

  // R10
  ack_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ack_o |-> acc_req_i);
  // R10
  fl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && !fl_ack_i) |=> fl_req_o && $stable(fl_addr_o));
  // R7
  sweep_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sweep_q |-> !acc_ack_o);
  // R3
  one_way_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOOK) |-> $onehot0(way_hit));
endmodule

// File: tb/flash_line_cache_bench.sv
`timescale 1ns/1ps
module flash_line_cache_bench;
  localparam int FL_LAT   = 3;
  localparam int HIT_LAT  = 1;
  localparam int MISS_LAT = 1 + FL_LAT;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [3:0]   cfg_addr = '0;
  logic [31:0]  cfg_wdata = '0;
  logic [31:0]  cfg_rdata;
  logic         acc_req = 1'b0;
  logic         acc_instr = 1'b0;
  logic [31:0]  acc_addr = '0;
  logic         acc_ack;
  logic [31:0]  acc_rdata;
  logic         fl_req;
  logic [31:0]  fl_addr;
  logic         fl_ack = 1'b0;
  logic [127:0] fl_line = '0;

  int n_chk = 0, n_bad = 0, fl_cnt = 0, last_lat = 0;
  logic [31:0] fl_last = '0;
  logic [31:0] gen = 32'h0000_1234;

  always #2 clk = ~clk;

  flash_line_cache u_flash_line_cache (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .acc_req_i(acc_req),
    .acc_instr_i(acc_instr), .acc_addr_i(acc_addr), .acc_ack_o(acc_ack),
    .acc_rdata_o(acc_rdata), .fl_req_o(fl_req), .fl_addr_o(fl_addr),
    .fl_ack_i(fl_ack), .fl_line_i(fl_line)
  );

  function automatic logic [31:0] mk(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_0000 ^ gen;
  endfunction

  // flash model
  initial begin
    int wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (fl_ack) fl_ack = 1'b0;
      else if (fl_req) begin
        wait_cnt++;
        if (wait_cnt == FL_LAT) begin
          wait_cnt = 0;
          fl_last  = fl_addr;
          fl_cnt++;
          for (int k = 0; k < 4; k++) fl_line[32*k +: 32] = mk(fl_addr + 32'(4*k));
          fl_ack = 1'b1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic acc(input logic [31:0] a, input logic ins, output logic [31:0] d);
    @(negedge clk);
    acc_req = 1'b1; acc_addr = a; acc_instr = ins;
    last_lat = 0;
    do begin
      @(negedge clk);
      #1 last_lat++;
    end while (!acc_ack && last_lat < 200);
    d = acc_rdata;
    @(negedge clk);
    acc_req = 1'b0;
  endtask

  // one access with checks on data, flash use and counter deltas
  task automatic xacc(input logic [31:0] a, input logic ins, input bit exp_fl,
                      input int dh, input int dm, input string r);
    logic [31:0] h0, m0, h1, m1, d;
    int f0;
    reg_rd(REG_HITS_I, h0); reg_rd(REG_MISS_I, m0);
    f0 = fl_cnt;
    acc(a, ins, d);
    reg_rd(REG_HITS_I, h1); reg_rd(REG_MISS_I, m1);
    chk(d == mk(a), r, "read data", d, mk(a));
    chk((fl_cnt != f0) == exp_fl, r, "flash used", 32'(fl_cnt - f0), 32'(exp_fl));
    chk(h1 - h0 == 32'(dh), r, "hit delta", h1 - h0, 32'(dh));
    chk(m1 - m0 == 32'(dm), r, "miss delta", m1 - m0, 32'(dm));
  endtask

  localparam logic [3:0] REG_CFG_I = 4'd0, REG_CTRL_I = 4'd1, REG_HITS_I = 4'd2,
                         REG_MISS_I = 4'd3;

  task automatic cfg(input logic [1:0] geo, input logic [1:0] mode, input logic lru);
    reg_wr(REG_CFG_I, {27'b0, lru, mode, geo});
    reg_wr(REG_CTRL_I, 32'h1);
  endtask

  task automatic inval();
    logic [31:0] d;
    int n = 0;
    reg_wr(REG_CTRL_I, 32'h4);
    do begin reg_rd(REG_CTRL_I, d); n++; end while (!d[1] && n < 2000);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_rd(REG_CFG_I, d);  chk(d == 0, "R1", "config word", d, 0);
    reg_rd(REG_CTRL_I, d); chk(d == 2, "R1", "control word", d, 2);
    reg_rd(REG_HITS_I, d); chk(d == 0, "R1", "hits", d, 0);
    reg_rd(REG_MISS_I, d); chk(d == 0, "R1", "misses", d, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    reg_wr(REG_CFG_I, 32'h0C);
    reg_rd(REG_CTRL_I, d); chk(d[0] == 0, "R9", "enable after config", d, 2);
    xacc(32'h100, 1, 1, 0, 0, "R9");
    reg_wr(REG_CTRL_I, 32'h1);
    xacc(32'h100, 1, 1, 0, 1, "R9");
    xacc(32'h100, 1, 0, 1, 0, "R9");
    reg_wr(REG_CFG_I, 32'h0C);
    xacc(32'h100, 1, 1, 0, 0, "R9");
    reg_wr(REG_CTRL_I, 32'h1);
    xacc(32'h100, 1, 0, 1, 0, "R9");
    reg_wr(REG_CTRL_I, 32'h2);
    xacc(32'h100, 1, 1, 0, 0, "R9");
  endtask

  task automatic t_line();
    inval(); cfg(2'd0, 2'd3, 1'b0);
    xacc(32'h20C, 0, 1, 0, 1, "R2");
    chk(fl_last == 32'h200, "R2", "line address", fl_last, 32'h200);
    chk(last_lat == MISS_LAT, "R10", "miss latency", 32'(last_lat), 32'(MISS_LAT));
    xacc(32'h200, 0, 0, 1, 0, "R2");
    chk(last_lat == HIT_LAT, "R10", "hit latency", 32'(last_lat), 32'(HIT_LAT));
    xacc(32'h204, 1, 0, 1, 0, "R2");
  endtask

  task automatic t_mode();
    inval(); cfg(2'd0, 2'd1, 1'b0);
    xacc(32'h300, 1, 1, 0, 1, "R4");
    xacc(32'h300, 0, 1, 0, 0, "R4");
    xacc(32'h300, 1, 0, 1, 0, "R4");
    cfg(2'd0, 2'd2, 1'b0);
    xacc(32'h300, 0, 0, 1, 0, "R4");
    xacc(32'h300, 1, 1, 0, 0, "R4");
    cfg(2'd0, 2'd0, 1'b0);
    xacc(32'h300, 0, 1, 0, 0, "R4");
  endtask

  task automatic t_geom();
    inval(); cfg(2'd0, 2'd3, 1'b0);
    xacc(32'h0100, 0, 1, 0, 1, "R3");
    xacc(32'h2100, 0, 1, 0, 1, "R3");
    xacc(32'h0100, 0, 1, 0, 1, "R3");
    inval(); cfg(2'd2, 2'd3, 1'b0);
    xacc(32'h0100, 0, 1, 0, 1, "R3");
    xacc(32'h2100, 0, 1, 0, 1, "R3");
    xacc(32'h0100, 0, 0, 1, 0, "R3");
    xacc(32'h4100, 0, 1, 0, 1, "R3");
    xacc(32'h0100, 0, 1, 0, 1, "R3");
    inval(); cfg(2'd1, 2'd3, 1'b0);
    xacc(32'h0100, 0, 1, 0, 1, "R3");
    xacc(32'h2100, 0, 1, 0, 1, "R3");
    xacc(32'h0100, 0, 0, 1, 0, "R3");
    xacc(32'h2100, 0, 0, 1, 0, "R3");
  endtask

  task automatic t_policy();
    inval(); cfg(2'd1, 2'd3, 1'b1);
    xacc(32'h0100, 0, 1, 0, 1, "R5");
    xacc(32'h2100, 0, 1, 0, 1, "R5");
    xacc(32'h0100, 0, 0, 1, 0, "R5");
    xacc(32'h4100, 0, 1, 0, 1, "R5");
    xacc(32'h0100, 0, 0, 1, 0, "R5");
    xacc(32'h2100, 0, 1, 0, 1, "R5");
    inval(); cfg(2'd1, 2'd3, 1'b0);
    xacc(32'h0100, 0, 1, 0, 1, "R5");
    xacc(32'h2100, 0, 1, 0, 1, "R5");
    xacc(32'h0100, 0, 0, 1, 0, "R5");
    xacc(32'h4100, 0, 1, 0, 1, "R5");
    xacc(32'h0100, 0, 1, 0, 1, "R5");
  endtask

  task automatic t_bypass();
    inval(); cfg(2'd0, 2'd3, 1'b0);
    reg_wr(4'd4, 32'h3000); reg_wr(4'd5, 32'h300F);
    reg_wr(4'd6, 32'h5000); reg_wr(4'd7, 32'h4000);
    reg_wr(4'd8, 32'h3);
    xacc(32'h3000, 1, 1, 0, 0, "R6");
    xacc(32'h3000, 1, 1, 0, 0, "R6");
    xacc(32'h300C, 0, 1, 0, 0, "R6");
    xacc(32'h3010, 0, 1, 0, 1, "R6");
    xacc(32'h3010, 0, 0, 1, 0, "R6");
    xacc(32'h4800, 1, 1, 0, 1, "R6");
    xacc(32'h4800, 1, 0, 1, 0, "R6");
    reg_wr(4'd8, 32'h2);
    xacc(32'h3000, 1, 1, 0, 1, "R6");
    xacc(32'h3000, 1, 0, 1, 0, "R6");
    reg_wr(4'd8, 32'h0);
  endtask

  task automatic t_inval();
    logic [31:0] d, old;
    int n = 0;
    inval(); cfg(2'd0, 2'd3, 1'b0);
    xacc(32'h600, 0, 1, 0, 1, "R7");
    old = mk(32'h600);
    gen = gen ^ 32'h0000_0F0F;
    acc(32'h600, 0, d);
    chk(d == old, "R7", "resident line before sweep", d, old);
    reg_wr(REG_CTRL_I, 32'h4);
    do begin reg_rd(REG_CTRL_I, d); n++; end while (!d[1] && n < 2000);
    chk(n == 512, "R7", "sweep cycles until ready", 32'(n), 512);
    xacc(32'h600, 0, 1, 0, 1, "R7");
  endtask

  task automatic t_stats();
    logic [31:0] d;
    reg_wr(REG_CTRL_I, 32'h8);
    reg_rd(REG_HITS_I, d); chk(d == 0, "R8", "hits after clear", d, 0);
    reg_rd(REG_MISS_I, d); chk(d == 0, "R8", "misses after clear", d, 0);
    xacc(32'h600, 0, 0, 1, 0, "R8");
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_line();
    t_mode();
    t_geom();
    t_policy();
    t_bypass();
    t_inval();
    t_stats();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule